// File: doc/BRIEF.md
# LCD Panel Power-Up Sequencer

This block orders the turn-on and turn-off of a parallel-RGB TFT panel. It drives three enables: one for the logic supply, one for the analog supply, and one for the video-signal drivers. The video-signal drivers carry the pixel clock, the syncs and the pixel data. The block also drives the display-on line. Every delay is counted in pixel-clock cycles. At 9 MHz the defaults give 450,000 cycles from logic supply to video signals and 4,500 cycles from video signals to display-on.

The display-on line may only rise while the vertical sync is high. The vertical sync comes from a separate timing generator, so the block first passes it through a two-flop synchronizer. The display-on rise waits for the synchronized level to be high.

Shutdown runs in the reverse order:

1. Display-on drops while the video keeps running.
2. A panel-off acknowledge arrives. The analog supply and the video drivers then drop.
3. One cycle later the logic supply drops.

Withdrawing the power request during power-up leaves by the same shutdown path.

Top module: `lcd_pwr_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, every output is low.
- R2: In the idle state, `pwr_req` sampled high raises `vcc_en` on that clock edge. `avdd_en`, `sig_en`, `disp` and `ready` stay low.
- R3: `avdd_en` and `sig_en` rise together exactly SIG_CYC clock edges after `vcc_en` rose. `avdd_en` is never high while `vcc_en` is low.
- R4: With the synchronized vertical sync already high, `disp` rises exactly DISP_CYC+1 edges after `sig_en` rose.
- R5: `disp` rises only when the synchronized vertical sync was high on the previous cycle. Suppose `vsync_in` is first sampled high at edge k+1, counting the `sig_en` rise edge as 0. Then `disp` rises at edge max(DISP_CYC+1, k+3).
- R6: `ready` is high exactly when `disp` is high, that is, only while the display is fully on.
- R7: When `pwr_req` is sampled low while the display is on, `disp` and `ready` fall on that edge. `sig_en`, `avdd_en` and `vcc_en` stay high until the acknowledge.
- R8: When `off_ack` is sampled high while the block waits for it, `sig_en` and `avdd_en` fall on that edge with `vcc_en` still high. `vcc_en` falls on the next edge.
- R9: When `pwr_req` is sampled low before the video signals start, `vcc_en` stays high for one more cycle and then falls. When it is sampled low after the video signals started but before display-on, the block waits for `off_ack` with `disp` held low, then finishes as in R8.
- R10: `off_ack` has no effect outside the acknowledge wait. A `pwr_req` raised again during the shutdown path does not stop it: the path finishes with `vcc_en` low for at least one cycle.
- R11: Once `disp` is high, a low vertical sync does not drop it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock; all delays count its cycles |
| rst | input | 1 | Synchronous reset, active high |
| pwr_req | input | 1 | Level request: high to power the panel, low to shut it down |
| vsync_in | input | 1 | Vertical sync level from the timing generator (asynchronous to this block) |
| off_ack | input | 1 | Panel-off acknowledge, sampled only while waiting after display-off |
| vcc_en | output | 1 | Logic supply enable |
| avdd_en | output | 1 | Analog supply enable |
| sig_en | output | 1 | Enable for the sync generator and the video-signal drivers |
| disp | output | 1 | Display-on line to the panel |
| ready | output | 1 | High only while the panel is fully on |

## Verification
All outputs are registered from the next-state decode. A response to `pwr_req` or `off_ack` therefore appears on the same edge that samples the input, and the bench samples 2 ns after that edge. The milestone delays are measured by counting edges from the previous milestone. The expected counts are SIG_CYC and DISP_CYC+1. A change on `vsync_in` reaches `disp` only on the third edge, through the two synchronizer flops and the state register. The randomized trials raise the vertical sync at a random edge k after `sig_en`. The bench predicts the `disp` edge as the later of DISP_CYC+1 and k+3, and checks that this is the first edge on which `disp` is high.

// File: rtl/lcdpwr_pkg.sv
package lcdpwr_pkg;

  typedef enum logic [2:0] {
    PS_OFF,
    PS_VCC_ON,
    PS_SIGNALS_ON,
    PS_WAIT_VSYNC_HIGH,
    PS_DISPLAY_ON,
    PS_DISP_OFF,
    PS_SHUTDOWN
  } pwr_state_e;

  typedef struct packed {
    logic vcc;
    logic avdd;
    logic sig;
    logic disp;
  } rail_set_t;

  // Delay in clock cycles for a time in microseconds at a given clock rate.
  function automatic int unsigned us_to_cycles(longint unsigned hz, longint unsigned us);
    return 32'((hz * us) / 64'd1_000_000);
  endfunction

  // Which enables are on in each state.
  function automatic rail_set_t rails_for(pwr_state_e s);
    rail_set_t r;
    r = '0;
    case (s)
      PS_VCC_ON, PS_SHUTDOWN:                       r.vcc = 1'b1;
      PS_SIGNALS_ON, PS_WAIT_VSYNC_HIGH, PS_DISP_OFF: begin
        r.vcc  = 1'b1;
        r.avdd = 1'b1;
        r.sig  = 1'b1;
      end
      PS_DISPLAY_ON:                                r = '1;
      default:                                      r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lcdpwr_sync.sv
module lcdpwr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/lcdpwr_dwell.sv
module lcdpwr_dwell #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic [W-1:0] limit,
  output logic         expired
);

  logic [W-1:0] cnt;

  assign expired = (cnt == limit - W'(1));

  always_ff @(posedge clk) begin
    if (rst || clear)  cnt <= '0;
    else if (!expired) cnt <= cnt + W'(1);
  end

  // R3/R4: the dwell count never runs past the limit it is timing.
  a_r3_dwell_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt < limit);

endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq import lcdpwr_pkg::*; #(
  parameter int unsigned CLK_HZ        = 9_000_000,
  parameter int unsigned SIG_DELAY_US  = 50_000,
  parameter int unsigned DISP_DELAY_US = 500,
  parameter int unsigned SIG_CYC       = us_to_cycles(CLK_HZ, SIG_DELAY_US),
  parameter int unsigned DISP_CYC      = us_to_cycles(CLK_HZ, DISP_DELAY_US),
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_req,
  input  logic vsync_in,
  input  logic off_ack,
  output logic vcc_en,
  output logic avdd_en,
  output logic sig_en,
  output logic disp,
  output logic ready
);

  localparam int unsigned MAX_CYC = (SIG_CYC > DISP_CYC) ? SIG_CYC : DISP_CYC;
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);

  pwr_state_e  state, state_nx;
  rail_set_t   rails_q, rails_nx;
  logic        vs_sync;
  logic        dwell_clear;
  logic        dwell_done;
  logic [CW-1:0] dwell_limit;
  logic        ack_event;
  logic        abort_event;

  lcdpwr_sync #(.STAGES(SYNC_STAGES)) u_vs_sync (
    .clk (clk),
    .rst (rst),
    .d   (vsync_in),
    .q   (vs_sync)
  );

  assign dwell_clear = (state_nx != state);
  assign dwell_limit = (state == PS_VCC_ON) ? CW'(SIG_CYC) : CW'(DISP_CYC);

  lcdpwr_dwell #(.W(CW)) u_dwell (
    .clk     (clk),
    .rst     (rst),
    .clear   (dwell_clear),
    .limit   (dwell_limit),
    .expired (dwell_done)
  );

  assign ack_event   = (state == PS_DISP_OFF) && off_ack;
  assign abort_event = !pwr_req &&
                       (state inside {PS_VCC_ON, PS_SIGNALS_ON, PS_WAIT_VSYNC_HIGH});

  always_comb begin
    state_nx = state;
    case (state)
      PS_OFF:             if (pwr_req)     state_nx = PS_VCC_ON;
      PS_VCC_ON:          if (!pwr_req)    state_nx = PS_SHUTDOWN;
                          else if (dwell_done) state_nx = PS_SIGNALS_ON;
      PS_SIGNALS_ON:      if (!pwr_req)    state_nx = PS_DISP_OFF;
                          else if (dwell_done) state_nx = PS_WAIT_VSYNC_HIGH;
      PS_WAIT_VSYNC_HIGH: if (!pwr_req)    state_nx = PS_DISP_OFF;
                          else if (vs_sync) state_nx = PS_DISPLAY_ON;
      PS_DISPLAY_ON:      if (!pwr_req)    state_nx = PS_DISP_OFF;
      PS_DISP_OFF:        if (off_ack)     state_nx = PS_SHUTDOWN;
      PS_SHUTDOWN:                         state_nx = PS_OFF;
      default:                             state_nx = PS_OFF;
    endcase
  end

  assign rails_nx = rails_for(state_nx);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= PS_OFF;
      rails_q <= '0;
      ready   <= 1'b0;
    end else begin
      state   <= state_nx;
      rails_q <= rails_nx;
      ready   <= (state_nx == PS_DISPLAY_ON);
    end
  end

  assign vcc_en  = rails_q.vcc;
  assign avdd_en = rails_q.avdd;
  assign sig_en  = rails_q.sig;
  assign disp    = rails_q.disp;

  // R3: analog supply only with logic supply present
  a_r3_avdd_after_vcc: assert property (@(posedge clk) disable iff (rst)
    avdd_en |-> vcc_en);

  // R3: video drivers start only after the logic supply was already up
  a_r3_sig_after_vcc: assert property (@(posedge clk) disable iff (rst)
    $rose(sig_en) |-> $past(vcc_en));

  // R5: display-on rises only while synchronized vsync was high
  a_r5_disp_rise_gated: assert property (@(posedge clk) disable iff (rst)
    $rose(disp) |-> $past(vs_sync));

  // R6: ready tracks the fully-on condition
  a_r6_ready_is_disp: assert property (@(posedge clk) disable iff (rst)
    ready == disp);

  // R7: display-on is never high without every supply and the video
  a_r7_disp_needs_all: assert property (@(posedge clk) disable iff (rst)
    disp |-> (sig_en && avdd_en && vcc_en));

  // R8: acknowledge removes video and analog supply, logic supply remains
  a_r8_ack_drops_video: assert property (@(posedge clk) disable iff (rst)
    ack_event |=> (!sig_en && !avdd_en && vcc_en));

  // R9: an abort never leaves display-on high
  a_r9_abort_no_disp: assert property (@(posedge clk) disable iff (rst)
    abort_event |=> !disp);

endmodule

// File: tb/lcd_pwr_seq_tb.sv
module lcd_pwr_seq_tb;

  localparam int SIG  = 20;
  localparam int DISP = 10;

  logic clk = 1'b0;
  logic rst, pwr_req, vsync_in, off_ack;
  logic vcc_en, avdd_en, sig_en, disp, ready;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  lcd_pwr_seq #(.SIG_CYC(SIG), .DISP_CYC(DISP)) u_dut (
    .clk(clk), .rst(rst), .pwr_req(pwr_req), .vsync_in(vsync_in),
    .off_ack(off_ack), .vcc_en(vcc_en), .avdd_en(avdd_en),
    .sig_en(sig_en), .disp(disp), .ready(ready)
  );

  // Expected edge of the display-on rise, counted from the video start edge.
  function automatic int exp_disp_edge(int k);
    int a, b;
    a = DISP + 1;
    b = k + 3;
    return (a > b) ? a : b;
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rails(string req, logic v, logic a, logic s, logic d);
    chk(req, {vcc_en, avdd_en, sig_en, disp, ready}, {v, a, s, d, d});
  endtask

  // Edges until sig_en is high; returns count.
  task automatic wait_sig(output int n);
    n = 0;
    do begin tick(); n++; end while (!sig_en && n < 1000);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int n, k, e;
    void'($urandom(32'd4711));
    rst = 1'b1; pwr_req = 1'b0; vsync_in = 1'b1; off_ack = 1'b0;
    repeat (3) tick();
    chk_rails("R1 in reset", 0, 0, 0, 0);
    rst = 1'b0;
    tick();
    chk_rails("R1 after reset", 0, 0, 0, 0);
    off_ack = 1'b1; tick(); off_ack = 1'b0;
    chk_rails("R10 ack while idle", 0, 0, 0, 0);

    // R2 / R3 / R4 / R6
    pwr_req = 1'b1; tick();
    chk_rails("R2 vcc first", 1, 0, 0, 0);
    wait_sig(n);
    chk("R3 sig delay", n, SIG);
    chk("R3 avdd with sig", avdd_en, 1);
    n = 0;
    do begin tick(); n++; end while (!disp && n < 1000);
    chk("R4 disp delay", n, DISP + 1);
    chk("R6 ready on", ready, 1);

    // R11 / R10
    vsync_in = 1'b0;
    repeat (30) tick();
    chk("R11 disp holds on low vsync", disp, 1);
    off_ack = 1'b1; tick(); off_ack = 1'b0;
    chk_rails("R10 ack while on", 1, 1, 1, 1);
    vsync_in = 1'b1;

    // R7 / R8 / R10
    pwr_req = 1'b0; tick();
    chk_rails("R7 disp first off", 1, 1, 1, 0);
    pwr_req = 1'b1;
    repeat (8) tick();
    chk_rails("R10 req ignored while waiting ack", 1, 1, 1, 0);
    off_ack = 1'b1; tick(); off_ack = 1'b0;
    chk_rails("R8 video and avdd off", 1, 0, 0, 0);
    tick();
    chk_rails("R10 vcc drops despite req", 0, 0, 0, 0);
    tick();
    chk_rails("R10 restart after off", 1, 0, 0, 0);
    pwr_req = 1'b0; tick();
    chk_rails("R9 abort holds vcc", 1, 0, 0, 0);
    tick();
    chk_rails("R9 abort vcc off", 0, 0, 0, 0);

    // R9: abort after video start, before display-on
    vsync_in = 1'b0;
    pwr_req = 1'b1; tick();
    wait_sig(n);
    repeat (3) tick();
    pwr_req = 1'b0; tick();
    chk_rails("R9 abort keeps video", 1, 1, 1, 0);
    vsync_in = 1'b1;
    repeat (2 * DISP) tick();
    chk_rails("R9 disp stays low", 1, 1, 1, 0);
    off_ack = 1'b1; tick(); off_ack = 1'b0;
    chk_rails("R9 ack drops video", 1, 0, 0, 0);
    tick();
    chk_rails("R9 vcc off", 0, 0, 0, 0);

    // R5: randomized vsync rise relative to the video start
    for (int t = 0; t < 24; t++) begin
      vsync_in = 1'b0;
      repeat (4) tick();
      k = (t < 4) ? t * 6 : $urandom_range(0, 2 * DISP + 6);
      pwr_req = 1'b1; tick();
      wait_sig(n);
      e = 0;
      do begin
        if (e == k) vsync_in = 1'b1;
        tick(); e++;
      end while (!disp && e < 1000);
      chk("R5 deferred disp edge", e, exp_disp_edge(k));
      pwr_req = 1'b0; tick();
      repeat ($urandom_range(0, 5)) tick();
      chk_rails("R7 random shutdown", 1, 1, 1, 0);
      off_ack = 1'b1; tick(); off_ack = 1'b0;
      tick();
      chk_rails("R8 random shutdown done", 0, 0, 0, 0);
    end

    finish_run();
  end

endmodule